// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device. It decides whether a program or erase operation that software has already started on the device has ended. A single start pulse loads a status address. The poller then reads that address in pairs over a simple master handshake and watches one status bit, the toggle bit, which flips on every read while the device is busy. It also watches a second bit, the timeout flag, which the device raises when an internal operation has run past its limit.

When the toggle bit reads the same twice in a row, the operation has ended, and the poller reports success. If the bit is still flipping when the timeout flag shows, the poller takes one more pair of reads. This covers the case where the flipping stopped at the same moment the flag rose. If the bit is still flipping after that extra pair, the poller writes the reset command to the device itself and reports failure. A parameterised pair limit guards against a device that never answers. Each result is given as a one-cycle pulse that carries a two-bit code.

Top module: `toggle_poller`

## Requirements
- R1: After reset the poller is idle: `busy_o`, `done_o`, `bus_req_o` and `bus_we_o` are 0 and `result_o` is 0 (no result).
- R2: A `start_i` pulse while idle latches `addr_i`. Every bus transfer of that operation uses this address. A `start_i` seen while busy is ignored, and its address never reaches the bus.
- R3: The poller has at most one request outstanding. `bus_req_o` stays high, with address and direction held, until `bus_ready_i` is seen high on a clock edge, and that edge completes the transfer. Status reads have `bus_we_o` = 0.
- R4: Status reads come in pairs. If bit 6 (the toggle bit) is the same in both words of a pair, the operation ends with code 2'b01 (success).
- R5: If bit 6 differs within a pair and bit 5 (the timeout flag) of the second word is 0, a new pair of reads follows.
- R6: If bit 6 differs and bit 5 of the second word is 1, one re-check pair is read. If bit 6 matches in that pair, the code is 2'b01.
- R7: If bit 6 still differs in the re-check pair, the poller makes exactly one write of 8'hF0 (zero-extended) to the latched address. When that write completes, it ends with code 2'b10 (failure).
- R8: When `MAX_PAIRS` ordinary pairs have all shown toggling without the timeout flag, the operation ends with code 2'b11 (limit), and no reset write is made.
- R9: `done_o` is a one-cycle pulse. While it is high, `busy_o` is 0 and `result_o` holds the nonzero code, and `result_o` keeps that code until the next accepted start.
- R10: Every accepted start begins polling with the first read of a fresh pair and a cleared pair count, whatever earlier operations did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin polling (accepted only when idle) |
| addr_i | input | AW | Status address for the operation |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 01 success, 10 failure, 11 limit reached |
| bus_req_o | output | 1 | Transfer request |
| bus_we_o | output | 1 | 1 for the reset write, 0 for status reads |
| bus_addr_o | output | AW | Transfer address |
| bus_wdata_o | output | DW | Write data |
| bus_ready_i | input | 1 | Transfer completes on an edge where this and the request are high |
| bus_rdata_i | input | DW | Read data, valid with `bus_ready_i` |

## Verification
The bench builds the poller with `MAX_PAIRS` = 4, a 12-bit address and a 16-bit data word. The small limit lets the limit outcome, and a run of three toggling pairs followed by a clean pair, be reached in a few dozen cycles. The bench's device model answers each request after zero, one or two wait cycles, in rotation. This spreads the back-to-back read pairs, the re-check pair and the reset write across different handshake timings. Two operations that each come close to the limit are run back to back, which shows that the pair count restarts. A start pulse with a different address is also injected in the middle of an operation.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_RC_A,
    ST_RC_B,
    ST_WR_RST
  } poll_state_e;

  localparam logic [1:0] RES_NONE  = 2'b00;
  localparam logic [1:0] RES_OK    = 2'b01;
  localparam logic [1:0] RES_FAIL  = 2'b10;
  localparam logic [1:0] RES_LIMIT = 2'b11;
endpackage

// File: rtl/poll_pair_cnt.sv
module poll_pair_cnt #(
  parameter int MAX_PAIRS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(MAX_PAIRS + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_PAIRS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // high when the pair now being judged is the final one allowed
  assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/poll_status_cmp.sv
module poll_status_cmp #(
  parameter int DW      = 16,
  parameter int TOG_BIT = 6,
  parameter int TMO_BIT = 5
) (
  input  logic [DW-1:0] first_word,
  input  logic [DW-1:0] second_word,
  output logic          toggled,
  output logic          timed_out
);
  assign toggled   = first_word[TOG_BIT] ^ second_word[TOG_BIT];
  assign timed_out = second_word[TMO_BIT];
endmodule

// File: rtl/toggle_poller.sv
module toggle_poller #(
  parameter int           AW        = 20,
  parameter int           DW        = 16,
  parameter int           MAX_PAIRS = 64,
  parameter int           TOG_BIT   = 6,
  parameter int           TMO_BIT   = 5,
  parameter logic [7:0]   RESET_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ready_i,
  input  logic [DW-1:0] bus_rdata_i
);
  import poll_pkg::*;

  localparam logic [DW-1:0] CMD_WORD = DW'(RESET_CMD);

  poll_state_e   state, nxt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] first_q;
  logic          req_q, we_q, done_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    res_q;

  logic          fin;
  logic [1:0]    fin_code;
  logic          cnt_clr, cnt_inc, cnt_last;
  logic          toggled, timed_out;
  logic          xfer;

  assign xfer = req_q & bus_ready_i;

  poll_status_cmp #(
    .DW(DW), .TOG_BIT(TOG_BIT), .TMO_BIT(TMO_BIT)
  ) u_cmp (
    .first_word (first_q),
    .second_word(bus_rdata_i),
    .toggled    (toggled),
    .timed_out  (timed_out)
  );

  poll_pair_cnt #(.MAX_PAIRS(MAX_PAIRS)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .last(cnt_last)
  );

  always_comb begin
    nxt      = state;
    fin      = 1'b0;
    fin_code = RES_NONE;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    unique case (state)
      ST_IDLE: if (start_i) begin
        nxt     = ST_RD_A;
        cnt_clr = 1'b1;
      end
      ST_RD_A: if (xfer) nxt = ST_RD_B;
      ST_RD_B: if (xfer) begin
        if (!toggled) begin
          fin = 1'b1; fin_code = RES_OK;
        end else if (timed_out) begin
          nxt = ST_RC_A;
        end else begin
          cnt_inc = 1'b1;
          if (cnt_last) begin
            fin = 1'b1; fin_code = RES_LIMIT;
          end else begin
            nxt = ST_RD_A;
          end
        end
      end
      ST_RC_A: if (xfer) nxt = ST_RC_B;
      ST_RC_B: if (xfer) begin
        if (!toggled) begin
          fin = 1'b1; fin_code = RES_OK;
        end else begin
          nxt = ST_WR_RST;
        end
      end
      ST_WR_RST: if (xfer) begin
        fin = 1'b1; fin_code = RES_FAIL;
      end
      default: nxt = ST_IDLE;
    endcase
    if (fin) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      first_q <= '0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      res_q   <= RES_NONE;
    end else begin
      state   <= nxt;
      req_q   <= (nxt != ST_IDLE);
      we_q    <= (nxt == ST_WR_RST);
      wdata_q <= (nxt == ST_WR_RST) ? CMD_WORD : '0;
      done_q  <= fin;
      if (state == ST_IDLE && start_i) begin
        addr_q <= addr_i;
        res_q  <= RES_NONE;
      end
      if (fin) res_q <= fin_code;
      if (xfer && (state == ST_RD_A || state == ST_RC_A))
        first_q <= bus_rdata_i;
    end
  end

  assign busy_o      = (state != ST_IDLE);
  assign done_o      = done_q;
  assign result_o    = res_q;
  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
endmodule

// File: rtl/poll_checker.sv
module poll_checker #(
  parameter int         AW        = 20,
  parameter int         DW        = 16,
  parameter logic [7:0] RESET_CMD = 8'hF0
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          done_o,
  input logic [1:0]    result_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_ready_i
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req_o && !bus_ready_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));
  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req_o |-> busy_o);
  // R2
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) |-> $stable(bus_addr_o));
  // R7
  reset_word_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req_o && bus_we_o |-> bus_wdata_o[7:0] == RESET_CMD);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9
  done_code_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && result_o != 2'b00);
  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !done_o && $past(!busy_o) |-> $stable(result_o));
endmodule

bind toggle_poller poll_checker #(.AW(AW), .DW(DW), .RESET_CMD(RESET_CMD)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i)
);

// File: tb/toggle_poller_tb.sv
module toggle_poller_tb;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MP = 4;

  localparam logic [DW-1:0] W_T   = 16'h0040;
  localparam logic [DW-1:0] W_N   = 16'h0000;
  localparam logic [DW-1:0] W_T5  = 16'h0060;
  localparam logic [DW-1:0] W_N5  = 16'h0020;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic busy_o, done_o, bus_req_o, bus_we_o, bus_ready_i;
  logic [1:0] result_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o, bus_rdata_i;

  always #2 clk = ~clk;

  toggle_poller #(.AW(AW), .DW(DW), .MAX_PAIRS(MP)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i), .bus_rdata_i(bus_rdata_i)
  );

  int checks = 0, failures = 0;
  int cycles = 0;
  logic [DW-1:0] stat_q[$];
  int n_rd, n_wr, dly_seed = 0, wait_n = 0;
  logic [DW-1:0] wr_seen;
  logic [AW-1:0] exp_addr;
  logic dev_rdy = 1'b0;
  logic watching = 1'b0;

  assign bus_ready_i = dev_rdy;

  always @(posedge clk) cycles++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model: answers each request after a rotating 0..2 cycle wait
  always @(negedge clk) begin
    if (dev_rdy) begin
      if (bus_we_o) begin
        n_wr++;
        wr_seen = bus_wdata_o;
      end else begin
        n_rd++;
        if (stat_q.size() > 0) void'(stat_q.pop_front());
      end
      dev_rdy <= 1'b0;
      wait_n  = dly_seed % 3;
      dly_seed++;
    end else if (bus_req_o) begin
      if (wait_n == 0) begin
        dev_rdy     <= 1'b1;
        bus_rdata_i <= (stat_q.size() > 0) ? stat_q[0] : W_N;
      end else begin
        wait_n--;
      end
    end
  end

  // per-clock reference comparisons
  always @(negedge clk) begin
    if (watching) begin
      #1;
      if (bus_req_o) check(bus_addr_o == exp_addr, "R2 transfer address", bus_addr_o, exp_addr);
      if (done_o) check(!busy_o, "R9 busy low at done", busy_o, 0);
      if (!busy_o) check(!bus_req_o, "R3 no request while idle", bus_req_o, 0);
    end
  end

  // behavioural expectation from the scripted status words
  task automatic expect_of(output logic [1:0] code, output int rd, output int wr);
    int i = 0, pairs = 0;
    logic [DW-1:0] w[$];
    w = stat_q;
    wr = 0;
    forever begin
      logic [DW-1:0] a, b;
      a = w[i]; b = w[i+1]; i += 2;
      if (a[6] == b[6]) begin code = 2'b01; break; end
      if (b[5]) begin
        a = w[i]; b = w[i+1]; i += 2;
        if (a[6] == b[6]) code = 2'b01;
        else begin code = 2'b10; wr = 1; end
        break;
      end
      pairs++;
      if (pairs == MP) begin code = 2'b11; break; end
    end
    rd = i;
  endtask

  task automatic run_op(input logic [AW-1:0] a, input bit poke, input string req);
    logic [1:0] ecode;
    int erd, ewr;
    expect_of(ecode, erd, ewr);
    n_rd = 0; n_wr = 0; wr_seen = '0;
    exp_addr = a;
    @(negedge clk); start_i = 1'b1; addr_i = a;
    @(negedge clk); start_i = 1'b0;
    if (poke) begin
      start_i = 1'b1; addr_i = ~a;   // R2: must be ignored while busy
      @(negedge clk); start_i = 1'b0; addr_i = a;
    end
    while (!done_o && cycles < 150000) begin
      @(negedge clk); #1;
    end
    check(cycles < 150000, {req, " watchdog"}, cycles, 0);
    check(result_o == ecode, {req, " result code"}, result_o, ecode);
    check(n_rd == erd, {req, " read count"}, n_rd, erd);
    check(n_wr == ewr, {req, " write count"}, n_wr, ewr);
    if (ewr != 0) check(wr_seen == 16'h00F0, "R7 reset write data", wr_seen, 16'h00F0);
    @(negedge clk); #1;
    check(!done_o, "R9 done single cycle", done_o, 0);
    check(result_o == ecode, "R9 code held", result_o, ecode);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!busy_o && !done_o && !bus_req_o && !bus_we_o, "R1 idle after reset", busy_o, 0);
    check(result_o == 2'b00, "R1 result after reset", result_o, 0);
    watching = 1'b1;

    // R4 stable at once
    stat_q = '{W_T, W_T};
    run_op(12'h0A5, 1'b0, "R4");
    // R5 two toggling pairs then stable; R2 start poke mid-operation
    stat_q = '{W_T, W_N, W_N, W_T, W_T, W_T};
    run_op(12'h3C1, 1'b1, "R5");
    // R6 timeout flag then recheck stable
    stat_q = '{W_T, W_N5, W_N5, W_N5};
    run_op(12'h111, 1'b0, "R6");
    // R7 recheck still toggling
    stat_q = '{W_N, W_T5, W_N5, W_T5};
    run_op(12'h7F0, 1'b0, "R7");
    // R8 pair limit
    stat_q = '{W_T, W_N, W_N, W_T, W_T, W_N, W_N, W_T};
    run_op(12'h222, 1'b0, "R8");
    // R10 two near-limit operations back to back
    stat_q = '{W_T, W_N, W_N, W_T, W_T, W_N, W_N, W_N};
    run_op(12'h050, 1'b0, "R10 first");
    stat_q = '{W_N, W_T, W_T, W_N, W_N, W_T, W_T, W_T};
    run_op(12'h051, 1'b0, "R10 second");

    watching = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #700000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule